// File: doc/BRIEF.md
# Device Idle Standby Timer Bank

A bank of independent countdown timers, one per peripheral device. Each timer measures how long its device has gone without an access to its trapped address range. When the programmed idle count runs out, the bank reports an expiry event for that device. If the global standby SMI enable is set, it also raises a system management interrupt request, so power-management firmware can put the idle device into standby.

A small enable register holds one bit per timer. Setting a bit arms and loads that timer, and every trapped access to the device restarts it. Time advances only on a tick strobe that comes from an external prescaler, so the idle period does not depend on the core clock. The reload values and the global SMI enable are plain inputs driven by the surrounding power-management logic.

Top module: `stb_timer_bank`

## Requirements
- R1: The enable register (one bit per timer, bit i controls timer i) resets to all zeros. A cycle with `wr_en_i` high stores `wr_data_i`, and `en_o` shows the new value on the next cycle. Without a write it keeps its value.
- R2: Writing a 1 to an enable bit that is currently 0 loads that timer with its initial count from `init_i` and arms it.
- R3: An access strobe `access_i[i]` loads timer i with its initial count and arms it, whether the timer is enabled or not.
- R4: An enabled, armed timer whose count is 2 or more decrements by exactly one in each cycle with `tick_i` high. It holds its count in cycles without a tick.
- R5: A timer whose enable bit is 0 holds its count on ticks and never signals expiry.
- R6: On a tick, an enabled, armed timer with count 1 goes to 0 and expires: `expired_o[i]` is high for exactly one cycle, in the cycle after that tick. The timer then stays at 0 and does not expire again until it is reloaded.
- R7: When a reload (access or enable rise) and a tick occur in the same cycle, the reload takes effect and the tick is discarded.
- R8: `smi_req_o` pulses for one cycle, together with `expired_o`, only if at least one timer expired and `smi_en_i` was 1 in the cycle of the expiring tick.
- R9: A timer loaded with an initial count of 0 expires on its next tick while enabled.
- R10: Writing a 1 to an enable bit that is already 1 does not reload that timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Enable register write strobe |
| wr_data_i | input | N_DEV | Enable register write data |
| en_o | output | N_DEV | Enable register contents |
| tick_i | input | 1 | Count tick strobe from prescaler |
| access_i | input | N_DEV | Per-device trapped access strobe |
| init_i | input | N_DEV*CNT_W | Initial counts, timer i at bits [i*CNT_W +: CNT_W] |
| smi_en_i | input | 1 | Global standby SMI enable |
| count_o | output | N_DEV*CNT_W | Current timer counts, same packing as init_i |
| expired_o | output | N_DEV | One-cycle expiry pulse per timer |
| smi_req_o | output | 1 | One-cycle SMI request pulse |

## Verification
On every cycle, assertions check the following: a disabled or tick-free timer keeps its count, a load produces the initial count one cycle later, expiry pulses are single and leave a zero count, the enable register follows writes, and an SMI request only follows an expiry with the global enable set. Some behaviours depend on the order of events, and only the bench scenarios can show them. These are the reload that wins over a same-cycle tick, the write to an already-set bit that must not restart a timer, and the immediate expiry of a zero initial count. The same applies to an access to a disabled timer that loads it without starting a countdown.

// File: rtl/stb_pkg.sv
package stb_pkg;
  parameter int unsigned STB_CNT_W = 16;
  parameter int unsigned STB_N_DEV = 4;
endpackage

// File: rtl/stb_enable_reg.sv
module stb_enable_reg #(
  parameter int unsigned N_DEV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [N_DEV-1:0] wr_data_i,
  output logic [N_DEV-1:0] en_o,
  output logic [N_DEV-1:0] rise_o
);
  logic [N_DEV-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (wr_en_i) en_q <= wr_data_i;
  end

  // only 0->1 transitions reload
  assign rise_o = {N_DEV{wr_en_i}} & wr_data_i & ~en_q;
  assign en_o   = en_q;

  assert_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> en_o == $past(wr_data_i));
  assert_keep_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(en_o));
endmodule

// File: rtl/stb_timer_ch.sv
module stb_timer_ch #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] init_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             step;
  logic             last;

  assign step   = run_i & tick_i & armed_q & ~load_i;
  assign last   = (cnt_q <= ONE);
  assign fire_o = step & last;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= init_i;
      armed_q <= 1'b1;
    end else if (step) begin
      if (last) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        cnt_q   <= cnt_q - ONE;
      end
    end
  end

  assert_hold_disabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_o));
  assert_hold_no_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_o));
  assert_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == $past(init_i));
  assert_single_fire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (!fire_o && cnt_o == '0));
endmodule

// File: rtl/stb_timer_bank.sv
module stb_timer_bank #(
  parameter int unsigned N_DEV = stb_pkg::STB_N_DEV,
  parameter int unsigned CNT_W = stb_pkg::STB_CNT_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [N_DEV-1:0]       wr_data_i,
  output logic [N_DEV-1:0]       en_o,
  input  logic                   tick_i,
  input  logic [N_DEV-1:0]       access_i,
  input  logic [N_DEV*CNT_W-1:0] init_i,
  input  logic                   smi_en_i,
  output logic [N_DEV*CNT_W-1:0] count_o,
  output logic [N_DEV-1:0]       expired_o,
  output logic                   smi_req_o
);
  logic [N_DEV-1:0] en;
  logic [N_DEV-1:0] rise;
  logic [N_DEV-1:0] fire;
  logic [N_DEV-1:0] exp_q;
  logic             smi_q;

  stb_enable_reg #(.N_DEV(N_DEV)) u_en (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .en_o     (en),
    .rise_o   (rise)
  );

  for (genvar g = 0; g < N_DEV; g++) begin : g_ch
    stb_timer_ch #(.CNT_W(CNT_W)) u_ch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (en[g]),
      .load_i(access_i[g] | rise[g]),
      .tick_i(tick_i),
      .init_i(init_i[g*CNT_W +: CNT_W]),
      .cnt_o (count_o[g*CNT_W +: CNT_W]),
      .fire_o(fire[g])
    );

    assert_exp_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expired_o[g] |-> (count_o[g*CNT_W +: CNT_W] == '0 || $past(access_i[g])));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= '0;
      smi_q <= 1'b0;
    end else begin
      exp_q <= fire;
      smi_q <= smi_en_i & (|fire);
    end
  end

  assign en_o      = en;
  assign expired_o = exp_q;
  assign smi_req_o = smi_q;

  assert_smi_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_req_o |-> $past(smi_en_i));
  assert_smi_needs_exp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_req_o |-> (expired_o != '0));
  assert_disabled_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o & ~$past(en)) == '0);
endmodule

// File: tb/stb_timer_bank_tb.sv
module stb_timer_bank_tb;
  localparam int N = 4;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [N-1:0]   wr_data = '0;
  logic [N-1:0]   en;
  logic           tick = 1'b0;
  logic [N-1:0]   access = '0;
  logic [N*W-1:0] init = '0;
  logic           smi_en = 1'b0;
  logic [N*W-1:0] count;
  logic [N-1:0]   expired;
  logic           smi_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int m_cnt [N];
  bit m_arm [N];
  bit m_en  [N];
  bit m_exp [N];
  bit m_smi;

  always #4 clk = ~clk;

  stb_timer_bank #(.N_DEV(N), .CNT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .en_o(en), .tick_i(tick), .access_i(access), .init_i(init),
    .smi_en_i(smi_en), .count_o(count), .expired_o(expired), .smi_req_o(smi_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int cnt_of(input int i);
    return int'(count[i*W +: W]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_cnt[i] = 0; m_arm[i] = 0; m_en[i] = 0; m_exp[i] = 0;
      end
      m_smi = 0;
    end else begin
      bit any;
      any = 0;
      for (int i = 0; i < N; i++) begin
        bit ld;
        ld = access[i] || (wr_en && wr_data[i] && !m_en[i]);
        m_exp[i] = 0;
        if (ld) begin
          m_cnt[i] = int'(init[i*W +: W]);
          m_arm[i] = 1;
        end else if (m_en[i] && tick && m_arm[i]) begin
          if (m_cnt[i] <= 1) begin
            m_cnt[i] = 0; m_arm[i] = 0; m_exp[i] = 1; any = 1;
          end else m_cnt[i] = m_cnt[i] - 1;
        end
      end
      m_smi = any && smi_en;
      if (wr_en) for (int i = 0; i < N; i++) m_en[i] = wr_data[i];
    end
  end

  // cycle compare against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < N; i++) begin
        chk("R1 enable", int'(en[i]), int'(m_en[i]));
        chk("R4 count", cnt_of(i), m_cnt[i]);
        chk("R6 expiry", int'(expired[i]), int'(m_exp[i]));
      end
      chk("R8 smi", int'(smi_req), int'(m_smi));
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clr();
    wr_en = 0; tick = 0; access = '0;
  endtask

  initial begin
    init[0*W +: W] = 16'd3;
    init[1*W +: W] = 16'd0;
    init[2*W +: W] = 16'd5;
    init[3*W +: W] = 16'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    chk("R1 reset en", int'(en), 0);
    chk("R1 reset count", int'(count == '0), 1);

    wr_en = 1; wr_data = 4'b0001; cyc(); clr();
    chk("R2 enable loads", cnt_of(0), 3);
    chk("R1 readback", int'(en), 1);

    cyc();
    chk("R4 hold without tick", cnt_of(0), 3);
    tick = 1; cyc(); clr();
    chk("R4 decrement", cnt_of(0), 2);
    chk("R5 disabled holds", cnt_of(2), 0);

    tick = 1; access = 4'b0001; cyc(); clr();
    chk("R7 reload wins", cnt_of(0), 3);

    tick = 1; cyc(); clr();
    wr_en = 1; wr_data = 4'b0001; cyc(); clr();
    chk("R10 no reload on set bit", cnt_of(0), 2);

    smi_en = 1;
    tick = 1; cyc();
    chk("R4 count to one", cnt_of(0), 1);
    cyc(); clr();
    chk("R6 count zero", cnt_of(0), 0);
    chk("R6 expired pulse", int'(expired[0]), 1);
    chk("R8 smi raised", int'(smi_req), 1);
    tick = 1; cyc(); clr();
    chk("R6 single pulse", int'(expired[0]), 0);
    chk("R6 stays zero", cnt_of(0), 0);

    access = 4'b1000; cyc(); clr();
    chk("R3 access loads disabled", cnt_of(3), 2);
    tick = 1; cyc(); clr();
    chk("R5 disabled no count", cnt_of(3), 2);
    chk("R5 disabled no expiry", int'(expired[3]), 0);

    smi_en = 0;
    wr_en = 1; wr_data = 4'b0011; cyc(); clr();
    tick = 1; cyc(); clr();
    chk("R9 zero count expires", int'(expired[1]), 1);
    chk("R8 smi gated off", int'(smi_req), 0);

    // random traffic against the model
    wr_en = 1; wr_data = 4'b1111; cyc(); clr();
    for (int k = 0; k < 3000; k++) begin
      tick   = ($urandom_range(0, 2) == 0);
      access = ($urandom_range(0, 9) == 0) ? 4'($urandom) : '0;
      smi_en = $urandom_range(0, 1);
      wr_en  = ($urandom_range(0, 40) == 0);
      wr_data = 4'($urandom);
      if ($urandom_range(0, 100) == 0)
        for (int i = 0; i < N; i++) init[i*W +: W] = 16'($urandom_range(0, 6));
      cyc();
    end
    clr();
    cyc();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule